// File: doc/BRIEF.md
# Display Reset and Wake-Up Gating Sequencer

This block sits on the host side of a display link and owns the active-low hardware reset line of the display controller. When a start request arrives while the block is idle, it drives the reset line low for a programmed width and then releases it. From that release point two independent hold-off windows run. The short window gates ordinary command traffic. The long window gates the command that wakes the display out of its low-power state. The long window exists because a display reset while awake can blank the panel for a long time.

A downstream command engine watches two registered flags. `cmd_ready_o` permits general commands. `wake_ok_o` permits the wake command. Every duration is set in microseconds and converted to system-clock cycles at elaboration, using a clock-frequency parameter in kHz. Each conversion rounds up, so no window is ever shorter than asked. The reset pulse width is clamped to at least 10 microseconds. Receivers reject or only partly act on pulses shorter than that, so a narrower setting cannot produce a pulse the display might ignore.

Top module: `disp_rst_seq`

## Requirements
- R1: While `srst_i` is high at a clock edge, the block goes idle with `disp_rst_n_o`, `cmd_ready_o` and `wake_ok_o` all low. `disp_rst_n_o` then stays low until a start request is accepted.
- R2: A `start_i` high at an edge while idle is accepted. From the next cycle `disp_rst_n_o` is low and both flags are low, deasserting together.
- R3: `disp_rst_n_o` stays low for exactly PULSE cycles after acceptance, then goes high. PULSE is the clamped pulse width converted to cycles.
- R4: The pulse width used is the larger of `PULSE_US` and 10 microseconds, so a smaller setting still yields a 10 us pulse.
- R5: `cmd_ready_o` goes high exactly SETTLE cycles after `disp_rst_n_o` goes high, and never while `disp_rst_n_o` is low.
- R6: `wake_ok_o` goes high exactly WAKE cycles after `disp_rst_n_o` goes high. It has its own timer, which runs in parallel with the SETTLE window.
- R7: A `start_i` that arrives during the pulse or during either hold-off window is ignored. The timing of the running sequence is unchanged.
- R8: Every duration in cycles is ceil(`CLK_KHZ` × microseconds / 1000), with a minimum of one cycle.
- R9: Once both flags are high the block is idle. Both flags and `disp_rst_n_o` stay high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| srst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run a reset sequence |
| disp_rst_n_o | output | 1 | Active-low reset to the display controller |
| cmd_ready_o | output | 1 | General command traffic allowed |
| wake_ok_o | output | 1 | Wake command allowed |

## Verification
The bench samples each output one cycle before and one cycle at every transition. A design off by one in the pulse, settle or wake counter therefore shows up as a wrong value at a boundary sample. A second instance uses a fractional clock-to-microsecond ratio and a pulse setting below the floor. A design that truncates instead of rounding up, or that honours the short pulse setting, releases reset or a flag one or more cycles early. Start requests are injected mid-pulse and mid-hold. A design that restarts on them moves the release and flag edges later. Requests are also issued after completion and under system reset, to catch flags that fail to drop together or a reset line that floats high after system reset.

// File: rtl/disp_rst_pkg.sv
package disp_rst_pkg;

    // Shortest reset pulse, in microseconds, that the receiver always honours.
    localparam int unsigned PULSE_FLOOR_US = 10;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PULSE = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic rst_n;
        logic ready;
        logic wake_ok;
    } seq_out_t;

    // Microseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned us_to_cycles(int unsigned khz, int unsigned us);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(khz) * longint'(us);
        cyc  = (prod + 64'd999) / 64'd1000;
        if (cyc == 64'd0) cyc = 64'd1;
        return 32'(cyc);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/seq_dly_timer.sv
module seq_dly_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         srst_i,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         fire_o,
    output logic         busy_o
);
    logic [W-1:0] cnt_q;
    logic         busy_q;

    // A load arms the timer for len_i cycles; fire_o marks the last one.
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (load_i) begin
            busy_q <= 1'b1;
            cnt_q  <= len_i - W'(1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end

    assign fire_o = busy_q && (cnt_q == '0);
    assign busy_o = busy_q;

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
    import disp_rst_pkg::*;
(
    input  logic     clk_i,
    input  logic     srst_i,
    input  logic     start_i,
    input  logic     phase_fire_i,
    input  logic     wake_fire_i,
    output logic     phase_load_o,
    output logic     phase_sel_settle_o,
    output logic     wake_load_o,
    output seq_out_t out_o
);
    seq_state_e state_q, state_d;
    seq_out_t   out_q, out_d;
    logic       ready_now, wake_now;

    always_comb begin
        state_d            = state_q;
        out_d              = out_q;
        phase_load_o       = 1'b0;
        phase_sel_settle_o = 1'b0;
        wake_load_o        = 1'b0;
        ready_now          = out_q.ready | phase_fire_i;
        wake_now           = out_q.wake_ok | wake_fire_i;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    state_d      = SEQ_PULSE;
                    out_d        = '0;
                    phase_load_o = 1'b1;
                end
            end
            SEQ_PULSE: begin
                if (phase_fire_i) begin
                    state_d            = SEQ_HOLD;
                    out_d.rst_n        = 1'b1;
                    phase_load_o       = 1'b1;
                    phase_sel_settle_o = 1'b1;
                    wake_load_o        = 1'b1;
                end
            end
            SEQ_HOLD: begin
                out_d.ready   = ready_now;
                out_d.wake_ok = wake_now;
                if (ready_now && wake_now) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            state_q <= SEQ_IDLE;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/disp_rst_seq.sv
module disp_rst_seq
    import disp_rst_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 100000,
    parameter int unsigned PULSE_US  = 10,
    parameter int unsigned SETTLE_US = 5000,
    parameter int unsigned WAKE_US   = 120000
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic start_i,
    output logic disp_rst_n_o,
    output logic cmd_ready_o,
    output logic wake_ok_o
);
    localparam int unsigned PULSE_CYC  = us_to_cycles(CLK_KHZ, max_u(PULSE_US, PULSE_FLOOR_US));
    localparam int unsigned SETTLE_CYC = us_to_cycles(CLK_KHZ, SETTLE_US);
    localparam int unsigned WAKE_CYC   = us_to_cycles(CLK_KHZ, WAKE_US);
    localparam int unsigned PHASE_W    = cnt_width(max_u(PULSE_CYC, SETTLE_CYC));
    localparam int unsigned WAKE_W     = cnt_width(WAKE_CYC);

    logic               phase_load, phase_sel_settle, phase_fire, phase_busy;
    logic               wake_load, wake_fire, wake_busy;
    logic [PHASE_W-1:0] phase_len;
    seq_out_t           seq_out;

    assign phase_len = phase_sel_settle ? PHASE_W'(SETTLE_CYC) : PHASE_W'(PULSE_CYC);

    seq_ctrl_fsm u_fsm (
        .clk_i              (clk_i),
        .srst_i             (srst_i),
        .start_i            (start_i),
        .phase_fire_i       (phase_fire),
        .wake_fire_i        (wake_fire),
        .phase_load_o       (phase_load),
        .phase_sel_settle_o (phase_sel_settle),
        .wake_load_o        (wake_load),
        .out_o              (seq_out)
    );

    // Shared by the reset pulse and the short settle window.
    seq_dly_timer #(.W(PHASE_W)) u_phase_tmr (
        .clk_i  (clk_i),
        .srst_i (srst_i),
        .load_i (phase_load),
        .len_i  (phase_len),
        .fire_o (phase_fire),
        .busy_o (phase_busy)
    );

    // Long window ahead of the wake command, runs alongside the settle window.
    seq_dly_timer #(.W(WAKE_W)) u_wake_tmr (
        .clk_i  (clk_i),
        .srst_i (srst_i),
        .load_i (wake_load),
        .len_i  (WAKE_W'(WAKE_CYC)),
        .fire_o (wake_fire),
        .busy_o (wake_busy)
    );

    assign disp_rst_n_o = seq_out.rst_n;
    assign cmd_ready_o  = seq_out.ready;
    assign wake_ok_o    = seq_out.wake_ok;

endmodule

// File: rtl/disp_rst_seq_chk.sv
module disp_rst_seq_chk #(
    parameter int unsigned PULSE_CYC = 1
) (
    input logic clk_i,
    input logic srst_i,
    input logic start_i,
    input logic disp_rst_n_o,
    input logic cmd_ready_o,
    input logic wake_ok_o
);
    logic [31:0] low_run;

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            low_run <= '0;
        end else if (!disp_rst_n_o) begin
            if (low_run != 32'hFFFF_FFFF) low_run <= low_run + 32'd1;
        end else begin
            low_run <= '0;
        end
    end

    AST_SRST_CLEARS: assert property (@(posedge clk_i)
        srst_i |=> (!disp_rst_n_o && !cmd_ready_o && !wake_ok_o)); // R1

    AST_FLAGS_DROP_TOGETHER: assert property (@(posedge clk_i) disable iff (srst_i)
        $fell(cmd_ready_o) |-> !wake_ok_o && !disp_rst_n_o); // R2

    AST_PULSE_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (srst_i)
        $rose(disp_rst_n_o) |-> (low_run >= PULSE_CYC)); // R3

    AST_READY_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (srst_i)
        cmd_ready_o |-> disp_rst_n_o); // R5

    AST_WAKE_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (srst_i)
        wake_ok_o |-> disp_rst_n_o); // R6

    AST_RELEASE_FLAGS_LOW: assert property (@(posedge clk_i) disable iff (srst_i)
        $rose(disp_rst_n_o) |-> (!cmd_ready_o && !wake_ok_o)); // R5

    AST_READY_HELD: assert property (@(posedge clk_i) disable iff (srst_i)
        (cmd_ready_o && !start_i) |=> cmd_ready_o); // R9

endmodule

bind disp_rst_seq disp_rst_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk_i        (clk_i),
    .srst_i       (srst_i),
    .start_i      (start_i),
    .disp_rst_n_o (disp_rst_n_o),
    .cmd_ready_o  (cmd_ready_o),
    .wake_ok_o    (wake_ok_o)
);

// File: tb/test_disp_rst_seq.sv
module test_disp_rst_seq;

    typedef struct packed {
        logic [15:0] t;
        logic [2:0]  exp;   // {rst_n, ready, wake_ok}
    } vec_t;

    // Instance A: 1 cycle per us, PULSE=10, SETTLE=40, WAKE=150
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'd0,   3'b000},
        '{16'd9,   3'b000},
        '{16'd10,  3'b100},
        '{16'd49,  3'b100},
        '{16'd50,  3'b110},
        '{16'd159, 3'b110},
        '{16'd160, 3'b111},
        '{16'd175, 3'b111}
    };

    logic clk = 1'b0;
    logic srst = 1'b1;
    logic start_a = 1'b0;
    logic start_b = 1'b0;
    logic rn_a, rdy_a, wk_a, rn_b, rdy_b, wk_b;
    int   checks = 0;
    int   fails = 0;
    int   tcur = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    disp_rst_seq #(.CLK_KHZ(1000), .PULSE_US(10), .SETTLE_US(40), .WAKE_US(150)) i_disp_rst_seq (
        .clk_i(clk), .srst_i(srst), .start_i(start_a),
        .disp_rst_n_o(rn_a), .cmd_ready_o(rdy_a), .wake_ok_o(wk_a));

    // Instance B: 1.5 cycles per us, pulse setting under the floor.
    // PULSE = 15, SETTLE = ceil(10.5) = 11, WAKE = ceil(31.5) = 32
    disp_rst_seq #(.CLK_KHZ(1500), .PULSE_US(4), .SETTLE_US(7), .WAKE_US(21)) i_disp_rst_seq_b (
        .clk_i(clk), .srst_i(srst), .start_i(start_b),
        .disp_rst_n_o(rn_b), .cmd_ready_o(rdy_b), .wake_ok_o(wk_b));

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0d actual=%b expected=%b", tag, tcur, act, exp);
        end
    endtask

    task automatic to_t(input int target);
        while (tcur < target) begin
            @(negedge clk);
            tcur++;
        end
    endtask

    task automatic pulse_a();
        @(negedge clk); start_a = 1'b1;
        @(negedge clk); start_a = 1'b0;
        tcur = 0;
    endtask

    task automatic pulse_b();
        @(negedge clk); start_b = 1'b1;
        @(negedge clk); start_b = 1'b0;
        tcur = 0;
    endtask

    // Start injected mid-sequence; tcur advances by one for the held cycle.
    task automatic poke_a();
        start_a = 1'b1;
        @(negedge clk); tcur++;
        start_a = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, line held low while idle with no start
        chk("R1 srst state A", {rn_a, rdy_a, wk_a}, 3'b000);
        srst = 1'b0;
        repeat (30) @(negedge clk);
        chk("R1 idle low after srst A", {rn_a, rdy_a, wk_a}, 3'b000);
        chk("R1 idle low after srst B", {rn_b, rdy_b, wk_b}, 3'b000);

        // Table walk: R2 R3 R5 R6 R9
        pulse_a();
        for (int i = 0; i < NV; i++) begin
            to_t(int'(VECS[i].t));
            chk("R2/R3/R5/R6 table", {rn_a, rdy_a, wk_a}, VECS[i].exp);
        end
        repeat (20) @(negedge clk);
        chk("R9 idle holds high", {rn_a, rdy_a, wk_a}, 3'b111);

        // R7: starts during pulse and during hold are ignored
        pulse_a();
        chk("R2 restart drops flags", {rn_a, rdy_a, wk_a}, 3'b000);
        to_t(5); poke_a();
        to_t(9);  chk("R7 pulse not restarted t9",  {rn_a, rdy_a, wk_a}, 3'b000);
        to_t(10); chk("R7 pulse not restarted t10", {rn_a, rdy_a, wk_a}, 3'b100);
        to_t(30); poke_a();
        to_t(49); chk("R7 settle unchanged t49", {rn_a, rdy_a, wk_a}, 3'b100);
        to_t(50); chk("R7 settle unchanged t50", {rn_a, rdy_a, wk_a}, 3'b110);
        to_t(60); poke_a();
        chk("R7 hold start ignored", {rn_a, rdy_a, wk_a}, 3'b110);
        to_t(159); chk("R7 wake unchanged t159", {rn_a, rdy_a, wk_a}, 3'b110);
        to_t(160); chk("R7 wake unchanged t160", {rn_a, rdy_a, wk_a}, 3'b111);

        // R4 R8: floor clamp and ceiling rounding on instance B
        pulse_b();
        chk("R2 B start", {rn_b, rdy_b, wk_b}, 3'b000);
        to_t(14); chk("R4 floor pulse low t14", {rn_b, rdy_b, wk_b}, 3'b000);
        to_t(15); chk("R4 floor pulse high t15", {rn_b, rdy_b, wk_b}, 3'b100);
        to_t(25); chk("R8 settle rounded t25", {rn_b, rdy_b, wk_b}, 3'b100);
        to_t(26); chk("R8 settle rounded t26", {rn_b, rdy_b, wk_b}, 3'b110);
        to_t(46); chk("R8 wake rounded t46", {rn_b, rdy_b, wk_b}, 3'b110);
        to_t(47); chk("R8 wake rounded t47", {rn_b, rdy_b, wk_b}, 3'b111);

        // R1: srst with start held wins and parks the line low
        @(negedge clk); srst = 1'b1; start_a = 1'b1;
        @(negedge clk); srst = 1'b0; start_a = 1'b0;
        chk("R1 srst overrides start", {rn_a, rdy_a, wk_a}, 3'b000);
        repeat (25) @(negedge clk);
        chk("R1 no sequence after srst", {rn_a, rdy_a, wk_a}, 3'b000);

        summary();
    end

endmodule